// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for an Ethernet PHY on a management bus, at register level. A host issues 32-bit command words that carry a device address, a register number, an opcode and a start flag. The block decodes each word in the cycle it is presented. A write stores the accompanying 16-bit data into one of 32 registers. A read returns 16 bits, one cycle later, on a read-data port.

Most registers are plain storage. Four registers are not read from storage. The basic status register, the link-partner ability register, the speed register and the diagnostic register are built at read time from the link-up input and from the current contents of the advertisement register. Commands aimed at any device address other than the configured one see no device. A read then returns all ones and a write has no effect.

The command word last presented can be read back, with a ready flag always set. A start flag with an opcode that is neither read nor write produces a one-cycle invalid-opcode pulse and no access.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and all other storage registers read 0x0000.
- R2: A read of register 1 returns 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) when linkUp is high at the command cycle, and 0x0000 when it is low.
- R3: A read of register 5 returns 0x4001 ORed with register 4 masked by 0x01E0 (bits 8:5).
- R4: A read of register 17 returns 0x8000 at all times, even after a write to it.
- R5: A read of register 18 returns 0x0000 while the link is down. While the link is up, bit 10 = reg4[7] | reg4[8] and bit 11 = reg4[8] | reg4[6], and all other bits are zero.
- R6: A write command stores wrData in the register selected by the 5-bit register field, and a later read of a plain storage register returns it.
- R7: Command fields: device address in bits 28:24, register in bits 20:16, opcode in bits 15:14, start in bit 11. Opcode 1 writes and opcode 2 reads. Without the start bit no access happens.
- R8: When the device address differs from parameter PHY_ADDR (default 7), a read returns 0xFFFF and a write changes no register.
- R9: cmdReadback shows the last command word presented with cmdValid, with bit 7 always set; after reset it reads 0x00000080.
- R10: A started command with opcode 0 or 3 raises invalidOp for exactly the next cycle, produces no rdValid and changes no register.
- R11: rdData and a one-cycle rdValid appear in the cycle after a read command. rdData holds its value until the next read. A write issued in one cycle is visible to a read issued in the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkUp | input | 1 | Link state used by the computed registers |
| cmdValid | input | 1 | A command word is presented this cycle |
| cmdWord | input | 32 | Command: device address, register, opcode, start |
| wrData | input | 16 | Data stored by a write command |
| rdData | output | 16 | Result of the last read command |
| rdValid | output | 1 | rdData was updated by a read in the previous cycle |
| invalidOp | output | 1 | One-cycle pulse for a started command with an unknown opcode |
| cmdReadback | output | 32 | Last command word, with the ready bit 7 forced high |

## Verification
Two kinds of event can meet in one cycle. The first is a change on linkUp that arrives with a read of a link-derived register. The bench drops linkUp in the same cycle it presents reads of registers 1 and 18, and expects the values for the new link state. The second is a write to the advertisement register followed at once by a read of register 5 or 18. The bench issues these back to back and expects the derived value to reflect the data just written.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_AW = 5;

  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [REG_AW-1:0] REG_STATUS  = 5'd1;
  localparam logic [REG_AW-1:0] REG_ADV     = 5'd4;
  localparam logic [REG_AW-1:0] REG_PARTNER = 5'd5;
  localparam logic [REG_AW-1:0] REG_SPEED   = 5'd17;
  localparam logic [REG_AW-1:0] REG_DIAG    = 5'd18;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              devHit;
    logic [REG_AW-1:0] regSel;
  } mgmt_strobe_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR  = 7,
  parameter int CMD_W     = 32,
  parameter int PHY_LSB   = 24,
  parameter int REG_LSB   = 16,
  parameter int OP_LSB    = 14,
  parameter int START_BIT = 11,
  parameter int READY_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  output mgmt_strobe_t     strobe,
  output logic             invalidOp,
  output logic [CMD_W-1:0] cmdReadback
);
  localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(PHY_ADDR);

  logic             started;
  logic [1:0]       opCode;
  logic [CMD_W-1:0] cmdReg;

  always_comb begin
    started       = cmdValid & cmdWord[START_BIT];
    opCode        = cmdWord[OP_LSB +: 2];
    strobe.wrEn   = started && (opCode == OP_WRITE);
    strobe.rdEn   = started && (opCode == OP_READ);
    strobe.devHit = (cmdWord[PHY_LSB +: REG_AW] == MY_ADDR);
    strobe.regSel = cmdWord[REG_LSB +: REG_AW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invalidOp <= 1'b0;
      cmdReg    <= '0;
    end else begin
      invalidOp <= started && (opCode != OP_WRITE) && (opCode != OP_READ);
      if (cmdValid) cmdReg <= cmdWord;
    end
  end

  assign cmdReadback = cmdReg | (CMD_W'(1) << READY_BIT);

  // R9: upper command bits are reproduced one cycle after capture
  assert_readback_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> cmdReadback[CMD_W-1:READY_BIT+1] == $past(cmdWord[CMD_W-1:READY_BIT+1]));
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  mgmt_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return DATA_W'(16'h3100);
      2:       return DATA_W'(16'h0300);
      3:       return DATA_W'(16'hE400);
      4:       return DATA_W'(16'h01E1);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [DATA_W-1:0] readMux;

  for (genvar i = 0; i < REG_COUNT; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[i] <= resetValue(i);
      else if (strobe.wrEn && strobe.devHit && (strobe.regSel == REG_AW'(i)))
        regs[i] <= wrData;
    end
  end

  always_comb begin
    readMux = regs[strobe.regSel];
    case (strobe.regSel)
      REG_STATUS:  readMux = linkUp ? DATA_W'(16'h782E) : '0;
      REG_PARTNER: readMux = DATA_W'(16'h4001) | (regs[REG_ADV] & DATA_W'(16'h01E0));
      REG_SPEED:   readMux = DATA_W'(16'h8000);
      REG_DIAG: begin
        readMux = '0;
        if (linkUp) begin
          readMux[10] = regs[REG_ADV][7] | regs[REG_ADV][8];
          readMux[11] = regs[REG_ADV][8] | regs[REG_ADV][6];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= strobe.devHit ? readMux : '1;
    end
  end

  assert_status_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.devHit && strobe.regSel == REG_STATUS && !linkUp) |=> rdData == '0);

  assert_speed_const_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.devHit && strobe.regSel == REG_SPEED) |=> rdData == DATA_W'(16'h8000));

  assert_diag_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.devHit && strobe.regSel == REG_DIAG && !linkUp) |=> rdData == '0);

  assert_miss_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !strobe.devHit) |=> rdData == '1);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData));
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR  = 7,
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 32,
  parameter int CMD_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              invalidOp,
  output logic [CMD_W-1:0]  cmdReadback
);
  mgmt_strobe_t strobe;

  phy_mgmt_ctrl #(.PHY_ADDR(PHY_ADDR), .CMD_W(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .strobe(strobe), .invalidOp(invalidOp), .cmdReadback(cmdReadback)
  );

  phy_mgmt_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) uRegs (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .strobe(strobe),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // R10: an invalid-opcode pulse never coincides with a read result
  assert_invalid_no_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> !rdValid);

  // R11: a read command yields rdValid in the next cycle
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[11] && cmdWord[15:14] == OP_READ) |=> rdValid);
endmodule

// File: tb/sim_phy_mgmt_responder.sv
module sim_phy_mgmt_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b1;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        invalidOp;
  logic [31:0] cmdReadback;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  phy_mgmt_responder u0 (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .invalidOp(invalidOp), .cmdReadback(cmdReadback)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [4:0] phy, input logic [4:0] rg,
                                      input logic [1:0] op, input logic st);
    return {3'b0, phy, 3'b0, rg, op, 2'b0, st, 11'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [15:0] d,
                       input bit isRead, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = w;
    wrData   = d;
    if (isRead) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
  endtask

  task automatic rd(input logic [4:0] rg, input logic [15:0] exp, input string tag);
    issue(mk(5'd7, rg, 2'd2, 1'b1), 16'h0, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [4:0] rg, input logic [15:0] d);
    issue(mk(5'd7, rg, 2'd1, 1'b1), d, 1'b0, 16'h0, "");
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: pops one expected item per read result
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R11 unexpected rdValid", 32'(rdValid), 32'd0);
      end else begin
        check(tagQ.pop_front(), 32'(rdData), 32'(expQ.pop_front()));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset readback", cmdReadback, 32'h0000_0080);
    check("R11 reset rdValid", 32'(rdValid), 32'd0);
    check("R10 reset invalidOp", 32'(invalidOp), 32'd0);
    rstN = 1'b1;

    rd(5'd0, 16'h3100, "R1 reg0");
    rd(5'd2, 16'h0300, "R1 reg2");
    rd(5'd3, 16'hE400, "R1 reg3");
    rd(5'd4, 16'h01E1, "R1 reg4");
    rd(5'd9, 16'h0000, "R1 reg9");
    rd(5'd1, 16'h782E, "R2 status up");
    rd(5'd5, 16'h41E1, "R3 partner default");
    rd(5'd17, 16'h8000, "R4 speed");
    rd(5'd18, 16'h0C00, "R5 diag default");

    wr(5'd4, 16'h0041);
    rd(5'd18, 16'h0800, "R5 diag adv bit6");
    rd(5'd5, 16'h4041, "R3 partner adv bit6");
    wr(5'd4, 16'h0081);
    rd(5'd5, 16'h4081, "R3 partner adv bit7");
    rd(5'd18, 16'h0400, "R5 diag adv bit7");
    wr(5'd4, 16'h0021);
    rd(5'd18, 16'h0000, "R5 diag no 100M or full");
    rd(5'd5, 16'h4021, "R3 partner adv bit5");

    wr(5'd9, 16'h1234);
    rd(5'd9, 16'h1234, "R6 reg9 store");
    wr(5'd31, 16'hA5A5);
    rd(5'd31, 16'hA5A5, "R6 reg31 store");
    wr(5'd17, 16'h1111);
    rd(5'd17, 16'h8000, "R4 speed after write");

    issue(mk(5'd7, 5'd9, 2'd1, 1'b0), 16'hDEAD, 1'b0, 16'h0, "");
    issue(mk(5'd7, 5'd9, 2'd2, 1'b0), 16'h0, 1'b0, 16'h0, "");
    rd(5'd9, 16'h1234, "R7 no start no access");

    issue(mk(5'd3, 5'd9, 2'd2, 1'b1), 16'h0, 1'b1, 16'hFFFF, "R8 miss read");
    issue(mk(5'd3, 5'd9, 2'd1, 1'b1), 16'h5555, 1'b0, 16'h0, "");
    rd(5'd9, 16'h1234, "R8 miss write ignored");
    idle();

    issue(mk(5'd7, 5'd9, 2'd3, 1'b1), 16'hBEEF, 1'b0, 16'h0, "");
    idle();
    check("R10 invalid op3 pulse", 32'(invalidOp), 32'd1);
    check("R10 invalid no rdValid", 32'(rdValid), 32'd0);
    check("R9 readback", cmdReadback, mk(5'd7, 5'd9, 2'd3, 1'b1) | 32'h80);
    @(negedge clk);
    check("R10 pulse ends", 32'(invalidOp), 32'd0);
    issue(mk(5'd7, 5'd9, 2'd0, 1'b1), 16'hBEEF, 1'b0, 16'h0, "");
    idle();
    check("R10 invalid op0 pulse", 32'(invalidOp), 32'd1);
    rd(5'd9, 16'h1234, "R10 no write on invalid op");

    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = mk(5'd7, 5'd1, 2'd2, 1'b1);
    linkUp   = 1'b0;
    expQ.push_back(16'h0000);
    tagQ.push_back("R2 status down same cycle");
    wr(5'd4, 16'h01E1);
    rd(5'd18, 16'h0000, "R5 diag link down");
    rd(5'd5, 16'h41E1, "R3 partner link down");
    wr(5'd12, 16'h7777);
    idle();
    check("R11 rdData held across write", 32'(rdData), 32'h41E1);
    check("R11 rdValid low after write", 32'(rdValid), 32'd0);
    linkUp = 1'b1;
    rd(5'd1, 16'h782E, "R2 status up again");
    rd(5'd12, 16'h7777, "R6 reg12 store");
    idle();
    check("R9 readback last", cmdReadback, mk(5'd7, 5'd12, 2'd2, 1'b1) | 32'h80);
    repeat (3) @(negedge clk);
    check("R11 all reads returned", 32'(expQ.size()), 32'd0);
    finishRun();
  end
endmodule